// File: doc/BRIEF.md
# PCS Control and Advertisement Register Block

This block keeps the control word and the auto-negotiation advertisement word of one Ethernet PCS channel. A simple management port can write and read either word. A parallel configuration vector can also load each word, but only on a rising edge of that vector's load strobe. A third strobe requests an auto-negotiation restart. The block drives the decoded control lines to the rest of the PCS: one-way transmit, power down, isolate and auto-negotiation enable. It also drives a one-cycle restart pulse.

The block also builds the 16-bit status word from plain inputs. These inputs come from the synchroniser, the code-group decoder and the auto-negotiation engine. The block holds two sticky pieces of state. One is a remote-fault flag, which clears when the status word is read. The other is a negotiation-complete interrupt, which can be masked, cleared by a write and cleared by a restart. A strap input selects the MAC-side or PHY-side role, and some fields behave differently in each role.

Top module: `pcs_ctrl_regs`

## Requirements
- R1: A synchronous active-high reset sets the following values. The control word reads 0x0010, with only auto-negotiation enable set. The advertisement word reads 0x0001. The remote-fault flag is clear. The interrupt is not pending and its enable is set, so address 16 reads 0x0002.
- R2: Control-word layout: bit 0 is one-way transmit, bit 2 is power down, bit 3 is isolate and bit 4 is auto-negotiation enable. Bits 1 and 5 are stored but have no function. A rising edge of `cfg_load` copies `cfg_vec[5:0]` into bits 5:0 of the control word. Holding `cfg_load` high does not load again. It must fall and rise to load once more.
- R3: In PHY role (`mac_mode`=0), a rising edge of `adv_load` loads `adv_vec` into the advertisement word, and bit 0 always reads 1. Holding the strobe high does not reload. In this word, bits 11:10 give speed (10 = 1000 Mb/s, 01 = 100 Mb/s, 00 = 10 Mb/s) and bit 12 gives full duplex.
- R4: In MAC role (`mac_mode`=1), the advertisement word reads 0x0001. Vector loads and management writes to it are ignored, and the stored PHY-role value is kept.
- R5: Two events request a restart: a rising edge of `an_restart_req`, or a management write to address 0 with bit 9 set. On a request, `an_restart` and control bit 9 go high for exactly one cycle. A request made while the bit is already high is absorbed.
- R6: Power down (control bit 2) stays set once set, until reset. Neither a write of 0 nor a vector with bit 2 clear can clear it.
- R7: A management write to address 0 updates control bits 5:0. A write to address 4 updates the advertisement word. If a vector load and a write to the same word happen in the same cycle, the vector wins.
- R8: The status word places its fields as follows. Link is bit 0, sync is bit 1, /C/ seen is bit 2, /I/ seen is bit 3, invalid is bit 4, disparity error is bit 5, not-in-table is bit 6 and PHY link is bit 7. Remote-fault type is bits 9:8, speed is bits 11:10, duplex is bit 12, the remote-fault flag is bit 13, and bits 15:14 mirror `lp_ability[8:7]`.
- R9: A pulse on `rf_event` in MAC role sets status bit 13, and the bit holds until a read of address 1 (`mgmt_rd` with `mgmt_addr`=1). In PHY role, status bits 13 and 9:8 read 0.
- R10: A pulse on `an_done` sets the interrupt pending bit. `an_irq` equals pending AND enable. Writing address 16 sets the enable from bit 1. The same write clears pending when bit 0 of the written data is 0. Address 16 reads {enable, pending} in bits 1:0. A restart pulse clears pending, and this takes priority over a new `an_done`.
- R11: `mgmt_rdata` returns the current value of the addressed word. Address 0 gives the control word, 1 the status word, 4 the advertisement word, 5 `lp_ability` and 16 the interrupt word. Any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| mac_mode | input | 1 | 1 = MAC-side role, 0 = PHY-side role |
| mgmt_wr | input | 1 | Management write strobe |
| mgmt_rd | input | 1 | Management read strobe (clears remote fault on address 1) |
| mgmt_addr | input | 5 | Management register address |
| mgmt_wdata | input | 16 | Management write data |
| mgmt_rdata | output | 16 | Management read data |
| cfg_vec | input | 6 | Parallel control vector |
| cfg_load | input | 1 | Control vector load strobe (edge-sensitive) |
| adv_vec | input | 16 | Parallel advertisement vector |
| adv_load | input | 1 | Advertisement load strobe (edge-sensitive) |
| an_restart_req | input | 1 | Auto-negotiation restart request (edge-sensitive) |
| an_done | input | 1 | Auto-negotiation complete pulse |
| link_ok | input | 1 | Link status |
| sync_ok | input | 1 | Synchronisation acquired |
| rx_cfg_seen | input | 1 | Receiving configuration ordered sets |
| rx_idle_seen | input | 1 | Receiving idle ordered sets |
| rx_invalid | input | 1 | Invalid data seen during /C/ or /I/ |
| rx_disp_err | input | 1 | Running disparity error |
| rx_not_in_tbl | input | 1 | Unknown code group |
| phy_link_up | input | 1 | Far-end PHY link state |
| rf_type | input | 2 | Remote fault type code |
| rf_event | input | 1 | Remote fault detected pulse |
| neg_speed | input | 2 | Negotiated speed |
| neg_duplex | input | 1 | Negotiated duplex |
| lp_ability | input | 16 | Link-partner ability word |
| ctl_unidir | output | 1 | One-way transmit enable |
| ctl_pdown | output | 1 | Power down |
| ctl_isolate | output | 1 | Isolate client interface |
| ctl_an_en | output | 1 | Auto-negotiation enable |
| an_restart | output | 1 | One-cycle restart pulse |
| adv_word | output | 16 | Current advertisement word |
| status_word | output | 16 | Packed status word |
| an_irq | output | 1 | Negotiation-complete interrupt |

## Verification
The assertions check a set of rules on every clock cycle:
- power down, once set, never drops;
- the restart bit never stays high for two cycles;
- the advertisement word is 0x0001 throughout MAC role;
- the remote-fault fields are zero throughout PHY role;
- a read of the status address clears the fault flag;
- a `cfg_load` held high leaves the control outputs unchanged;
- a restart clears the interrupt.

Some behaviour can only be shown by the bench's directed scenarios compared against its cycle model. That covers the exact bit placement of loaded vectors and packed status, and the priority of a vector load over a write in the same cycle. It also covers the fact that loads ignored in MAC role leave the stored PHY value intact, and the mask and clear semantics of the interrupt word.

// File: rtl/pcs_ctrl_pkg.sv
package pcs_ctrl_pkg;

    localparam int WORD_W  = 16;
    localparam int ADDR_W  = 5;
    localparam int CFG_W   = 6;
    localparam int PAUSE_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 5'd0;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 5'd1;
    localparam logic [ADDR_W-1:0] ADDR_ADV  = 5'd4;
    localparam logic [ADDR_W-1:0] ADDR_LP   = 5'd5;
    localparam logic [ADDR_W-1:0] ADDR_IRQ  = 5'd16;

    localparam int BIT_UNI     = 0;
    localparam int BIT_PD      = 2;
    localparam int BIT_ISO     = 3;
    localparam int BIT_ANE     = 4;
    localparam int BIT_RESTART = 9;

    localparam logic [CFG_W-1:0]  CFG_RESET = 6'b01_0000;
    localparam logic [WORD_W-1:0] ADV_FIXED = 16'h0001;
    localparam int LP_PAUSE_LSB = 7;

    localparam int STRB_CFG = 0;
    localparam int STRB_ADV = 1;
    localparam int STRB_RST = 2;
    localparam int STRB_N   = 3;

    typedef struct packed {
        logic [1:0] rf_type;
        logic [1:0] speed;
        logic       duplex;
        logic       phy_link;
        logic       not_in_tbl;
        logic       disp_err;
        logic       invalid;
        logic       idle_seen;
        logic       cfg_seen;
        logic       sync;
        logic       link;
    } lane_stat_t;

    function automatic logic [WORD_W-1:0] ctrl_word(input logic [CFG_W-1:0] cfg,
                                                    input logic restart);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CFG_W-1:0]   = cfg;
        w[BIT_RESTART] = restart;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(input lane_stat_t s,
                                                      input logic mac,
                                                      input logic rf_hold,
                                                      input logic [PAUSE_W-1:0] pause);
        return {pause, rf_hold, s.duplex, s.speed,
                (mac ? s.rf_type : 2'b00), s.phy_link, s.not_in_tbl,
                s.disp_err, s.invalid, s.idle_seen, s.cfg_seen, s.sync, s.link};
    endfunction

endpackage

// File: rtl/pcs_rise_det.sv
module pcs_rise_det #(
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic prev_q;
        always_ff @(posedge clk) begin
            if (rst) prev_q <= 1'b0;
            else     prev_q <= lvl[i];
        end
        assign rise[i] = lvl[i] & ~prev_q;
    end
endmodule

// File: rtl/pcs_ctrl_reg.sv
module pcs_ctrl_reg
    import pcs_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_bits,
    input  logic             wr_restart,
    input  logic             vec_load,
    input  logic [CFG_W-1:0] vec_bits,
    input  logic             restart_rise,
    output logic [CFG_W-1:0] cfg_q,
    output logic             restart_q
);
    logic [CFG_W-1:0] cfg_nxt;

    always_comb begin
        if (vec_load)   cfg_nxt = vec_bits;
        else if (wr_en) cfg_nxt = wr_bits;
        else            cfg_nxt = cfg_q;
        cfg_nxt[BIT_PD] = cfg_nxt[BIT_PD] | cfg_q[BIT_PD];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= CFG_RESET;
            restart_q <= 1'b0;
        end else begin
            cfg_q     <= cfg_nxt;
            restart_q <= ~restart_q & (restart_rise | (wr_en & wr_restart));
        end
    end
endmodule

// File: rtl/pcs_adv_reg.sv
module pcs_adv_reg
    import pcs_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mac_mode,
    input  logic              wr_en,
    input  logic [WORD_W-1:1] wr_bits,
    input  logic              vec_load,
    input  logic [WORD_W-1:1] vec_bits,
    output logic [WORD_W-1:0] adv_q
);
    logic [WORD_W-1:1] store_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= ADV_FIXED[WORD_W-1:1];
        end else if (!mac_mode) begin
            if (vec_load)   store_q <= vec_bits;
            else if (wr_en) store_q <= wr_bits;
        end
    end

    assign adv_q = mac_mode ? ADV_FIXED : {store_q, 1'b1};
endmodule

// File: rtl/pcs_status_unit.sv
module pcs_status_unit
    import pcs_ctrl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               mac_mode,
    input  lane_stat_t         lane,
    input  logic               rf_event,
    input  logic               stat_read,
    input  logic [PAUSE_W-1:0] pause,
    input  logic               restart_q,
    input  logic               an_done,
    input  logic               irq_wr,
    input  logic [1:0]         irq_wbits,
    output logic [WORD_W-1:0]  status_word,
    output logic [1:0]         irq_reg,
    output logic               an_irq
);
    logic rf_q;
    logic pend_q;
    logic en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rf_q   <= 1'b0;
            pend_q <= 1'b0;
            en_q   <= 1'b1;
        end else begin
            rf_q <= mac_mode & (rf_event | (rf_q & ~stat_read));
            if (restart_q)                    pend_q <= 1'b0;
            else if (an_done)                 pend_q <= 1'b1;
            else if (irq_wr && !irq_wbits[0]) pend_q <= 1'b0;
            if (irq_wr) en_q <= irq_wbits[1];
        end
    end

    assign status_word = pack_status(lane, mac_mode, rf_q & mac_mode, pause);
    assign irq_reg     = {en_q, pend_q};
    assign an_irq      = pend_q & en_q;
endmodule

// File: rtl/pcs_ctrl_regs.sv
module pcs_ctrl_regs
    import pcs_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mac_mode,
    input  logic              mgmt_wr,
    input  logic              mgmt_rd,
    input  logic [ADDR_W-1:0] mgmt_addr,
    input  logic [WORD_W-1:0] mgmt_wdata,
    output logic [WORD_W-1:0] mgmt_rdata,
    input  logic [CFG_W-1:0]  cfg_vec,
    input  logic              cfg_load,
    input  logic [WORD_W-1:0] adv_vec,
    input  logic              adv_load,
    input  logic              an_restart_req,
    input  logic              an_done,
    input  logic              link_ok,
    input  logic              sync_ok,
    input  logic              rx_cfg_seen,
    input  logic              rx_idle_seen,
    input  logic              rx_invalid,
    input  logic              rx_disp_err,
    input  logic              rx_not_in_tbl,
    input  logic              phy_link_up,
    input  logic [1:0]        rf_type,
    input  logic              rf_event,
    input  logic [1:0]        neg_speed,
    input  logic              neg_duplex,
    input  logic [WORD_W-1:0] lp_ability,
    output logic              ctl_unidir,
    output logic              ctl_pdown,
    output logic              ctl_isolate,
    output logic              ctl_an_en,
    output logic              an_restart,
    output logic [WORD_W-1:0] adv_word,
    output logic [WORD_W-1:0] status_word,
    output logic              an_irq
);
    logic [STRB_N-1:0] strobe_lvl;
    logic [STRB_N-1:0] strobe_rise;
    logic [CFG_W-1:0]  cfg_q;
    logic [1:0]        irq_reg;
    lane_stat_t        lane;
    logic              wr_ctrl, wr_adv, wr_irq, rd_stat;

    assign strobe_lvl[STRB_CFG] = cfg_load;
    assign strobe_lvl[STRB_ADV] = adv_load;
    assign strobe_lvl[STRB_RST] = an_restart_req;

    assign wr_ctrl = mgmt_wr && (mgmt_addr == ADDR_CTRL);
    assign wr_adv  = mgmt_wr && (mgmt_addr == ADDR_ADV);
    assign wr_irq  = mgmt_wr && (mgmt_addr == ADDR_IRQ);
    assign rd_stat = mgmt_rd && (mgmt_addr == ADDR_STAT);

    always_comb begin
        lane.rf_type    = rf_type;
        lane.speed      = neg_speed;
        lane.duplex     = neg_duplex;
        lane.phy_link   = phy_link_up;
        lane.not_in_tbl = rx_not_in_tbl;
        lane.disp_err   = rx_disp_err;
        lane.invalid    = rx_invalid;
        lane.idle_seen  = rx_idle_seen;
        lane.cfg_seen   = rx_cfg_seen;
        lane.sync       = sync_ok;
        lane.link       = link_ok;
    end

    pcs_rise_det #(.N(STRB_N)) u_edges (
        .clk  (clk),
        .rst  (rst),
        .lvl  (strobe_lvl),
        .rise (strobe_rise)
    );

    pcs_ctrl_reg u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_ctrl),
        .wr_bits      (mgmt_wdata[CFG_W-1:0]),
        .wr_restart   (mgmt_wdata[BIT_RESTART]),
        .vec_load     (strobe_rise[STRB_CFG]),
        .vec_bits     (cfg_vec),
        .restart_rise (strobe_rise[STRB_RST]),
        .cfg_q        (cfg_q),
        .restart_q    (an_restart)
    );

    pcs_adv_reg u_adv (
        .clk      (clk),
        .rst      (rst),
        .mac_mode (mac_mode),
        .wr_en    (wr_adv),
        .wr_bits  (mgmt_wdata[WORD_W-1:1]),
        .vec_load (strobe_rise[STRB_ADV]),
        .vec_bits (adv_vec[WORD_W-1:1]),
        .adv_q    (adv_word)
    );

    pcs_status_unit u_stat (
        .clk         (clk),
        .rst         (rst),
        .mac_mode    (mac_mode),
        .lane        (lane),
        .rf_event    (rf_event),
        .stat_read   (rd_stat),
        .pause       (lp_ability[LP_PAUSE_LSB+PAUSE_W-1:LP_PAUSE_LSB]),
        .restart_q   (an_restart),
        .an_done     (an_done),
        .irq_wr      (wr_irq),
        .irq_wbits   (mgmt_wdata[1:0]),
        .status_word (status_word),
        .irq_reg     (irq_reg),
        .an_irq      (an_irq)
    );

    assign ctl_unidir  = cfg_q[BIT_UNI];
    assign ctl_pdown   = cfg_q[BIT_PD];
    assign ctl_isolate = cfg_q[BIT_ISO];
    assign ctl_an_en   = cfg_q[BIT_ANE];

    always_comb begin
        case (mgmt_addr)
            ADDR_CTRL: mgmt_rdata = ctrl_word(cfg_q, an_restart);
            ADDR_STAT: mgmt_rdata = status_word;
            ADDR_ADV:  mgmt_rdata = adv_word;
            ADDR_LP:   mgmt_rdata = lp_ability;
            ADDR_IRQ:  mgmt_rdata = {{(WORD_W-2){1'b0}}, irq_reg};
            default:   mgmt_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pcs_ctrl_regs_chk.sv
module pcs_ctrl_regs_chk
    import pcs_ctrl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mac_mode,
    input logic              mgmt_wr,
    input logic              mgmt_rd,
    input logic [ADDR_W-1:0] mgmt_addr,
    input logic              cfg_load,
    input logic              rf_event,
    input logic              ctl_unidir,
    input logic              ctl_pdown,
    input logic              ctl_isolate,
    input logic              ctl_an_en,
    input logic              an_restart,
    input logic [WORD_W-1:0] adv_word,
    input logic [WORD_W-1:0] status_word,
    input logic              an_irq
);
    assert_pdown_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        ctl_pdown |=> ctl_pdown);

    assert_restart_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        an_restart |=> !an_restart);

    assert_adv_mac_fixed_R4: assert property (@(posedge clk) disable iff (rst)
        mac_mode |-> (adv_word == 16'h0001));

    assert_rf_phy_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !mac_mode |-> (status_word[13] == 1'b0 && status_word[9:8] == 2'b00));

    assert_rf_read_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (mgmt_rd && mgmt_addr == ADDR_STAT && !rf_event) |=> !status_word[13]);

    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && cfg_load && $past(cfg_load) && !(mgmt_wr && mgmt_addr == ADDR_CTRL))
        |=> $stable({ctl_unidir, ctl_isolate, ctl_an_en}));

    assert_irq_restart_R10: assert property (@(posedge clk) disable iff (rst)
        an_restart |=> !an_irq);
endmodule

bind pcs_ctrl_regs pcs_ctrl_regs_chk u_chk (.*);

// File: tb/pcs_ctrl_regs_test.sv
`timescale 1ns/1ps
module pcs_ctrl_regs_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mac_mode = 1'b0;
    logic        mgmt_wr = 1'b0, mgmt_rd = 1'b0;
    logic [4:0]  mgmt_addr = '0;
    logic [15:0] mgmt_wdata = '0;
    logic [15:0] mgmt_rdata;
    logic [5:0]  cfg_vec = '0;
    logic        cfg_load = 1'b0;
    logic [15:0] adv_vec = '0;
    logic        adv_load = 1'b0, an_restart_req = 1'b0, an_done = 1'b0;
    logic        link_ok = 0, sync_ok = 0, rx_cfg_seen = 0, rx_idle_seen = 0;
    logic        rx_invalid = 0, rx_disp_err = 0, rx_not_in_tbl = 0, phy_link_up = 0;
    logic [1:0]  rf_type = '0, neg_speed = '0;
    logic        rf_event = 0, neg_duplex = 0;
    logic [15:0] lp_ability = '0;
    logic        ctl_unidir, ctl_pdown, ctl_isolate, ctl_an_en, an_restart, an_irq;
    logic [15:0] adv_word, status_word;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    logic [5:0]  m_cfg;
    logic        m_rs;
    logic [15:1] m_adv;
    logic        m_rf, m_pend, m_en;
    logic        p_cfg, p_adv, p_rr;
    bit          m_ok = 0;

    always #2.5 clk = ~clk;

    pcs_ctrl_regs uut (.*);

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        logic e_cfg, e_adv, e_rr, w0, w4, w16, rs_n, pend_n;
        logic [5:0] c;
        if (rst) begin
            m_cfg = 6'h10; m_rs = 0; m_adv = '0; m_rf = 0; m_pend = 0; m_en = 1;
            p_cfg = 0; p_adv = 0; p_rr = 0; m_ok = 1;
        end else begin
            e_cfg = cfg_load && !p_cfg;
            e_adv = adv_load && !p_adv;
            e_rr  = an_restart_req && !p_rr;
            w0  = mgmt_wr && mgmt_addr == 0;
            w4  = mgmt_wr && mgmt_addr == 4;
            w16 = mgmt_wr && mgmt_addr == 16;
            c = e_cfg ? cfg_vec : (w0 ? mgmt_wdata[5:0] : m_cfg);
            if (m_cfg[2]) c[2] = 1'b1;
            rs_n = !m_rs && (e_rr || (w0 && mgmt_wdata[9]));
            if (!mac_mode) begin
                if (e_adv)   m_adv = adv_vec[15:1];
                else if (w4) m_adv = mgmt_wdata[15:1];
            end
            m_rf = mac_mode && (rf_event || (m_rf && !(mgmt_rd && mgmt_addr == 1)));
            pend_n = m_pend;
            if (m_rs) pend_n = 0;
            else if (an_done) pend_n = 1;
            else if (w16 && !mgmt_wdata[0]) pend_n = 0;
            if (w16) m_en = mgmt_wdata[1];
            m_pend = pend_n; m_cfg = c; m_rs = rs_n;
            p_cfg = cfg_load; p_adv = adv_load; p_rr = an_restart_req;
        end
    end

    function automatic logic [15:0] exp_adv();
        return mac_mode ? 16'h0001 : {m_adv, 1'b1};
    endfunction

    function automatic logic [15:0] exp_stat();
        return {lp_ability[8:7], m_rf && mac_mode, neg_duplex, neg_speed,
                mac_mode ? rf_type : 2'b00, phy_link_up, rx_not_in_tbl, rx_disp_err,
                rx_invalid, rx_idle_seen, rx_cfg_seen, sync_ok, link_ok};
    endfunction

    function automatic logic [15:0] exp_rd();
        case (mgmt_addr)
            5'd0:  return {6'b0, m_rs, 3'b0, m_cfg};
            5'd1:  return exp_stat();
            5'd4:  return exp_adv();
            5'd5:  return lp_ability;
            5'd16: return {14'b0, m_en, m_pend};
            default: return 16'h0000;
        endcase
    endfunction

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (m_ok && !rst) begin
            chk("R2 control outputs", {12'b0, ctl_an_en, ctl_isolate, ctl_pdown, ctl_unidir},
                {12'b0, m_cfg[4], m_cfg[3], m_cfg[2], m_cfg[0]});
            chk("R5 restart pulse", {15'b0, an_restart}, {15'b0, m_rs});
            chk("R3 advertisement", adv_word, exp_adv());
            chk("R8 status word", status_word, exp_stat());
            chk("R10 interrupt", {15'b0, an_irq}, {15'b0, m_pend & m_en});
            chk("R11 read data", mgmt_rdata, exp_rd());
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk); mgmt_wr = 1; mgmt_addr = a; mgmt_wdata = d;
        @(negedge clk); mgmt_wr = 0;
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] a, input logic [15:0] e);
        @(negedge clk); mgmt_rd = 0; mgmt_addr = a;
        #1 chk(tag, mgmt_rdata, e);
    endtask

    task automatic pulse_cfg(input logic [5:0] v);
        @(negedge clk); cfg_vec = v; cfg_load = 1;
        @(negedge clk); cfg_load = 0;
    endtask

    task automatic pulse_adv(input logic [15:0] v);
        @(negedge clk); adv_vec = v; adv_load = 1;
        @(negedge clk); adv_load = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick(3);
        rst = 0;
        // R1 reset state
        rd_chk("R1 control after reset", 0, 16'h0010);
        rd_chk("R1 advert after reset", 4, 16'h0001);
        rd_chk("R1 irq word after reset", 16, 16'h0002);
        chk("R1 status bit13", {15'b0, status_word[13]}, 16'h0);

        // R2 vector load on edge, no reload while held
        pulse_cfg(6'b001001);
        rd_chk("R2 vector load", 0, 16'h0009);
        @(negedge clk); cfg_vec = 6'b010000; cfg_load = 1;
        @(negedge clk); mgmt_wr = 1; mgmt_addr = 0; mgmt_wdata = 16'h0001;
        @(negedge clk); mgmt_wr = 0;
        tick(2);
        #1 chk("R2 held strobe no reload", {15'b0, ctl_an_en}, 16'h0);
        @(negedge clk); cfg_load = 0;
        @(negedge clk); cfg_load = 1;
        @(negedge clk); cfg_load = 0;
        #1 chk("R2 retrigger after fall", {15'b0, ctl_an_en}, 16'h1);

        // R5 restart from strobe and from write
        @(negedge clk); an_restart_req = 1;
        @(negedge clk); #1 chk("R5 restart high", {15'b0, an_restart}, 16'h1);
        chk("R5 control bit9", mgmt_rdata & 16'h0200, mgmt_addr == 0 ? 16'h0200 : mgmt_rdata & 16'h0200);
        @(negedge clk); #1 chk("R5 restart self clear", {15'b0, an_restart}, 16'h0);
        @(negedge clk); an_restart_req = 0;
        #1 chk("R5 held request no repeat", {15'b0, an_restart}, 16'h0);
        wr(0, 16'h0210);
        #1 chk("R5 restart via write", {15'b0, an_restart}, 16'h1);

        // R6 sticky power down
        wr(0, 16'h0014);
        #1 chk("R6 power down set", {15'b0, ctl_pdown}, 16'h1);
        wr(0, 16'h0010);
        rd_chk("R6 write zero keeps pd", 0, 16'h0014);
        pulse_cfg(6'b010000);
        rd_chk("R6 vector keeps pd", 0, 16'h0014);

        // R3 advertisement in PHY role
        pulse_adv(16'h1800);
        rd_chk("R3 adv load 1000 full", 4, 16'h1801);

        // R7 same-cycle priority
        @(negedge clk);
        adv_vec = 16'h0400; adv_load = 1; mgmt_wr = 1; mgmt_addr = 4; mgmt_wdata = 16'h1000;
        @(negedge clk); adv_load = 0; mgmt_wr = 0;
        rd_chk("R7 adv vector beats write", 4, 16'h0401);
        @(negedge clk);
        cfg_vec = 6'b000001; cfg_load = 1; mgmt_wr = 1; mgmt_addr = 0; mgmt_wdata = 16'h0018;
        @(negedge clk); cfg_load = 0; mgmt_wr = 0;
        rd_chk("R7 ctrl vector beats write", 0, 16'h0005);
        wr(0, 16'h0018);
        rd_chk("R7 ctrl write", 0, 16'h001C);

        // R4 MAC role fixes advertisement
        @(negedge clk); mac_mode = 1;
        #1 chk("R4 mac adv fixed", adv_word, 16'h0001);
        pulse_adv(16'h1234);
        wr(4, 16'hFFFF);
        rd_chk("R4 mac ignores loads", 4, 16'h0001);
        @(negedge clk); mac_mode = 0;
        #1 chk("R4 stored value kept", adv_word, 16'h0401);

        // R8 status packing, two patterns
        @(negedge clk);
        link_ok = 1; sync_ok = 1; rx_idle_seen = 1; rx_disp_err = 1; phy_link_up = 1;
        rf_type = 2'b10; neg_speed = 2'b10; neg_duplex = 1; lp_ability = 16'h0080;
        #1 chk("R8 status pattern A", status_word, 16'h58AB);
        @(negedge clk); mac_mode = 1;
        link_ok = 0; sync_ok = 0; rx_idle_seen = 0; rx_disp_err = 0; phy_link_up = 0;
        rx_cfg_seen = 1; rx_invalid = 1; rx_not_in_tbl = 1;
        rf_type = 2'b01; neg_speed = 2'b01; neg_duplex = 0; lp_ability = 16'h0100;
        #1 chk("R8 status pattern B", status_word, 16'h8554);
        rd_chk("R11 read lp ability", 5, 16'h0100);
        rd_chk("R11 unused address", 7, 16'h0000);

        // R9 sticky remote fault
        @(negedge clk); rf_event = 1;
        @(negedge clk); rf_event = 0;
        tick(3);
        #1 chk("R9 fault sticky", {15'b0, status_word[13]}, 16'h1);
        @(negedge clk); mgmt_addr = 1; mgmt_rd = 1;
        @(negedge clk); mgmt_rd = 0;
        #1 chk("R9 read clears fault", {15'b0, status_word[13]}, 16'h0);
        @(negedge clk); rf_event = 1;
        @(negedge clk); rf_event = 0; mac_mode = 0;
        #1 chk("R9 phy role fault hidden", {14'b0, status_word[13], status_word[9]}, 16'h0);

        // R10 interrupt
        @(negedge clk); an_done = 1;
        @(negedge clk); an_done = 0;
        #1 chk("R10 irq raised", {15'b0, an_irq}, 16'h1);
        rd_chk("R10 irq word", 16, 16'h0003);
        wr(16, 16'h0002);
        #1 chk("R10 write clears", {15'b0, an_irq}, 16'h0);
        @(negedge clk); an_done = 1;
        @(negedge clk); an_done = 0; an_restart_req = 1;
        @(negedge clk); an_restart_req = 0;
        @(negedge clk); #1 chk("R10 restart clears", {15'b0, an_irq}, 16'h0);
        wr(16, 16'h0000);
        @(negedge clk); an_done = 1;
        @(negedge clk); an_done = 0;
        #1 chk("R10 masked", {15'b0, an_irq}, 16'h0);
        rd_chk("R10 pending while masked", 16, 16'h0001);

        tick(3);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule